// File: doc/BRIEF.md
# Audio Serial-Port Master Clock Generator

This block produces the bit clock and the frame (left/right) clock of an audio serial port when the device drives the port as bus master. There is no PLL in the path. Both clocks are divided straight down from one external master clock. A 2-bit oversampling code gives the number of master-clock cycles per sample period (the frame). A one-bit width select picks 32 or 64 bit-clock periods per frame. The legal combinations give bit-clock divide ratios of 4, 8, 16 and 32.

A single free-running frame counter drives both outputs. Each output is a registered tap on one bit of that counter, so the two clocks stay in phase by construction. Select changes are held back until the next frame boundary, so a change never produces a runt pulse. While the master-mode enable is low, both clocks are held low and the counter stays cleared. When the enable rises again, a fresh frame starts with a full left half. The master clock is expected to run whenever any converter path is enabled.

Top module: `asp_clkgen`

## Requirements
- R1: The frame length in master-clock cycles follows the code `osr_sel`: 00 gives 256, 01 gives 1024, 10 gives 256 and 11 gives 512.
- R2: `bck_wide` = 0 gives 32 bit-clock periods per frame and `bck_wide` = 1 gives 64. The bit-clock period is therefore the frame length divided by 32 or by 64. After reset the active selection is code 00 with `bck_wide` = 0.
- R3: Both outputs have a 50% duty cycle. The bit clock is high for half its period and the frame clock is high for half the frame.
- R4: The frame clock changes state only in the master-clock cycle in which the bit clock goes from 1 to 0.
- R5: The frame clock is low during the first (left) half of every frame and high during the second (right) half.
- R6: A change on `osr_sel` or `bck_wide` while the block is enabled takes effect only at the next frame boundary. The frame in progress completes with its old length and its old bit-clock rate.
- R7: A low `rst_n` drives both outputs low at once. A low `master_en` drives them low from the next master-clock edge. When `master_en` rises again, the first frame starts at its beginning with a full-length left half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | External master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Enables clock generation as serial-port master |
| osr_sel | input | 2 | Master-clock-to-sample-rate ratio code |
| bck_wide | input | 1 | Bit-clock rate select: 0 for 32fs, 1 for 64fs |
| bclk | output | 1 | Serial bit clock |
| fclk | output | 1 | Frame (left/right) clock at the sample rate |

## Verification
The hardest case to reach from the ports is a select change that lands within a cycle or two of a frame boundary. This tests whether the change is deferred or leaks into the running frame. The bench reaches it by timing a change from an observed frame-clock edge so that it falls just before the next wrap. It also makes changes at random points, and it drops the enable partway through a frame. A behavioural cycle model in the bench predicts both clocks on every master-clock edge. Period and high-time measurements are then taken for all eight select combinations.

// File: rtl/asp_clk_pkg.sv
package asp_clk_pkg;

   typedef struct packed {
      logic [1:0] code;
      logic       wide;
   } clk_cfg_t;

   localparam clk_cfg_t CFG_RESET = '{code: 2'b00, wide: 1'b0};

   // log2 of master-clock cycles per frame
   function automatic logic [3:0] frame_lg(input logic [1:0] code);
      case (code)
         2'b01:   return 4'd10;
         2'b11:   return 4'd9;
         default: return 4'd8;
      endcase
   endfunction

   // log2 of master-clock cycles per bit-clock period
   function automatic logic [3:0] bit_lg(input logic [1:0] code, input logic wide);
      return frame_lg(code) - (wide ? 4'd6 : 4'd5);
   endfunction

endpackage

// File: rtl/asp_frame_ctr.sv
module asp_frame_ctr
   import asp_clk_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  clk_cfg_t         cfg_in,
   output logic [CNT_W-1:0] cnt_o,
   output clk_cfg_t         cfg_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   clk_cfg_t         cfg_q;

   assign last = CNT_W'((32'd1 << frame_lg(cfg_q.code)) - 32'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cfg_q <= CFG_RESET;
      end else if (!en) begin
         cnt_q <= '0;
         cfg_q <= cfg_in;
      end else if (cnt_q == last) begin
         cnt_q <= '0;
         cfg_q <= cfg_in;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign cfg_o = cfg_q;

   a_r1_cnt_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last);

   a_r6_cfg_held_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && cnt_q != '0) |-> $stable(cfg_q));

endmodule

// File: rtl/asp_phase_tap.sv
module asp_phase_tap #(
   parameter int CNT_W = 10,
   localparam int IW   = $clog2(CNT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [IW-1:0]    idx,
   output logic             tap_o
);

   logic tap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tap_q <= 1'b0;
      else if (!en) tap_q <= 1'b0;
      else          tap_q <= cnt[idx];
   end

   assign tap_o = tap_q;

endmodule

// File: rtl/asp_clkgen.sv
module asp_clkgen
   import asp_clk_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic       mclk,
   input  logic       rst_n,
   input  logic       master_en,
   input  logic [1:0] osr_sel,
   input  logic       bck_wide,
   output logic       bclk,
   output logic       fclk
);

   localparam int IW = $clog2(CNT_W);

   generate
      if (CNT_W < 10) begin : g_width_bad
         $error("asp_clkgen: CNT_W must cover a 1024-cycle frame");
      end
   endgenerate

   clk_cfg_t         cfg_req, cfg_act;
   logic [CNT_W-1:0] cnt;
   logic [IW-1:0]    bit_idx, frm_idx;

   assign cfg_req = '{code: osr_sel, wide: bck_wide};

   asp_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(mclk), .rst_n(rst_n), .en(master_en),
      .cfg_in(cfg_req), .cnt_o(cnt), .cfg_o(cfg_act)
   );

   assign bit_idx = IW'(bit_lg(cfg_act.code, cfg_act.wide) - 4'd1);
   assign frm_idx = IW'(frame_lg(cfg_act.code) - 4'd1);

   asp_phase_tap #(.CNT_W(CNT_W)) u_bclk (
      .clk(mclk), .rst_n(rst_n), .en(master_en),
      .cnt(cnt), .idx(bit_idx), .tap_o(bclk)
   );

   asp_phase_tap #(.CNT_W(CNT_W)) u_fclk (
      .clk(mclk), .rst_n(rst_n), .en(master_en),
      .cnt(cnt), .idx(frm_idx), .tap_o(fclk)
   );

   a_r4_fclk_on_bclk_fall: assert property (@(posedge mclk) disable iff (!rst_n)
      (master_en && $past(master_en) && (fclk != $past(fclk))) |-> $fell(bclk));

   a_r5_left_half_first: assert property (@(posedge mclk) disable iff (!rst_n)
      (master_en && cnt == '0) |=> !fclk);

   a_r7_off_drives_low: assert property (@(posedge mclk) disable iff (!rst_n)
      !master_en |=> (!bclk && !fclk));

   a_r3_bclk_low_at_frame_start: assert property (@(posedge mclk) disable iff (!rst_n)
      (master_en && cnt == '0) |=> !bclk);

endmodule

// File: tb/sim_asp_clkgen.sv
module sim_asp_clkgen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [1:0] osr = 2'b00;
   logic       wide = 1'b0;
   logic       bclk, fclk;

   int  vec = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   asp_clkgen u0 (
      .mclk(clk), .rst_n(rst_n), .master_en(en),
      .osr_sel(osr), .bck_wide(wide), .bclk(bclk), .fclk(fclk)
   );

   function automatic int nlen(input logic [1:0] c);
      case (c)
         2'b01:   return 1024;
         2'b11:   return 512;
         default: return 256;
      endcase
   endfunction

   // behavioural reference model
   int   m_c, m_n, m_d;
   logic eb, ef;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_c = 0; m_n = 256; m_d = 8; eb = 0; ef = 0;
      end else if (!en) begin
         m_c = 0; m_n = nlen(osr); m_d = m_n / (wide ? 64 : 32); eb = 0; ef = 0;
      end else begin
         eb = ((m_c % m_d) >= m_d / 2);
         ef = (m_c >= m_n / 2);
         if (m_c == m_n - 1) begin
            m_c = 0; m_n = nlen(osr); m_d = m_n / (wide ? 64 : 32);
         end else begin
            m_c++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         chk(bclk === eb, "R2 R3 R4 R6 R7 bclk vs model", int'(bclk), int'(eb));
         chk(fclk === ef, "R1 R3 R4 R5 R6 R7 fclk vs model", int'(fclk), int'(ef));
      end
   end

   function automatic logic pick(input bit use_b);
      return use_b ? bclk : fclk;
   endfunction

   task automatic measure(input bit use_b, output int per, output int hi);
      logic pv;
      pv = pick(use_b);
      @(negedge clk);
      while (!(pick(use_b) && !pv)) begin pv = pick(use_b); @(negedge clk); end
      per = 0; hi = 0;
      do begin
         if (pick(use_b)) hi++;
         per++;
         pv = pick(use_b);
         @(negedge clk);
      end while (!(pick(use_b) && !pv));
   endtask

   task automatic run_combo(input logic [1:0] c, input logic w);
      int per, hi, n, d;
      @(negedge clk);
      osr = c; wide = w;
      n = nlen(c); d = n / (w ? 64 : 32);
      repeat (2 * 1024) @(negedge clk);
      measure(1'b0, per, hi);
      chk(per == n, "R1 frame length", per, n);
      chk(hi == n / 2, "R3 R5 frame high time", hi, n / 2);
      measure(1'b1, per, hi);
      chk(per == d, "R2 bit-clock period", per, d);
      chk(hi == d / 2, "R3 bit-clock high time", hi, d / 2);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(bclk === 1'b0 && fclk === 1'b0, "R7 outputs low in reset", int'({bclk, fclk}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(bclk === 1'b0 && fclk === 1'b0, "R7 outputs low while disabled", int'({bclk, fclk}), 0);
      en = 1'b1;
      repeat (600) @(negedge clk);   // default 256/32: R2 reset selection

      for (int c = 0; c < 4; c++)
         for (int w = 0; w < 2; w++)
            run_combo(2'(c), 1'(w));

      // R6: change just before a boundary, then at scattered points
      for (int k = 0; k < 6; k++) begin
         logic pv;
         pv = fclk;
         @(negedge clk);
         while (!(pv && !fclk)) begin pv = fclk; @(negedge clk); end
         repeat (nlen(osr) - 2 - k % 3) @(negedge clk);
         osr = 2'(k + 1); wide = ~wide;
         repeat (37 * k + 5) @(negedge clk);
         osr = 2'(k * 3); wide = k[0];
         repeat (700) @(negedge clk);
      end

      // R7: enable dropped mid-frame
      for (int k = 0; k < 3; k++) begin
         repeat (300 + 91 * k) @(negedge clk);
         en = 1'b0;
         @(negedge clk);
         chk(bclk === 1'b0 && fclk === 1'b0, "R7 low after enable drop", int'({bclk, fclk}), 0);
         repeat (3) @(negedge clk);
         osr = 2'(k); wide = k[0];
         en = 1'b1;
         repeat (1100) @(negedge clk);
      end

      // R7: asynchronous reset mid-run
      #3 rst_n = 1'b0;
      #1 chk(bclk === 1'b0 && fclk === 1'b0, "R7 async reset low", int'({bclk, fclk}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (700) @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vec++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

endmodule